// File: doc/BRIEF.md
# Shader Source Operand Fetch Unit

This block collects the three vector source operands of one 128-bit shader instruction and hands them to the arithmetic stage. The three instruction words that carry operand fields come in on one input. For each operand the block extracts a use flag, a 9-bit register index, a register group, an addressing mode, a swizzle byte and absolute/negate flags. It forms the effective index and reads one of three sources: the temporary register file, the uniform store, or the internal value group, which here carries the front-facing flag.

The raw vector then passes through its swizzle and its two sign modifiers. The three results appear, with a valid flag, one clock after the instruction strobe. The uniform store has a single read port, so an instruction can read only one uniform. When several live operands name uniforms, the uniform chosen by the highest-numbered of them is fed to all of them. Both register arrays are internal and sized by parameters. A plain write port loads them.

Top module: `shader_opfetch`

## Requirements
- R1: `inst_w` bits 31:0 hold instruction word 1, bits 63:32 word 2 and bits 95:64 word 3. Operand 0 fields: use w1[11], index w1[20:12], swizzle w1[29:22], negate w1[30], absolute w1[31], mode w2[2:0], group w2[5:3]. Operand 1 fields: use w2[6], index w2[15:7], swizzle w2[24:17], negate w2[25], absolute w2[26], mode w2[29:27], group w3[2:0]. Operand 2 fields: use w3[3], index w3[12:4], swizzle w3[21:14], negate w3[22], absolute w3[23], mode w3[27:25], group w3[30:28].
- R2: The output vector of an operand whose use flag is 0 is all zeros, and that operand has no part in the uniform choice.
- R3: Group codes are taken modulo 4, so 4..7 act as 0..3. Group 0 reads temporaries. Group 1 returns the internal vector: x is 32'h3F800000 when `front_facing` was high at the strobe and 0 otherwise, and y, z, w are 0. Group 2 reads uniform index+offset. Group 3 reads uniform 128+index+offset.
- R4: Mode 0 and modes 5..7 add no offset. Modes 1..4 add the signed `ADDR_W`-bit component x, y, z or w of `addr_reg` to the index. Component x sits in the lowest bits. The sum wraps modulo the depth of the array being read.
- R5: Vector component c occupies bits 32c+31:32c. Output component c takes input component swz[2c+1:2c].
- R6: After the swizzle, the absolute flag clears bit 31 of every component. The negate flag then inverts bit 31, so absolute plus negate always gives a set sign.
- R7: If more than one used operand is in group 2 or 3, the single uniform addressed by the highest-numbered such operand is read. Every uniform operand receives that uniform, with its own swizzle and sign modifiers applied.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The outputs change only then and hold their values while no strobe arrives, whatever is on the inputs.
- R9: While `rst` is high, and after it until the first strobe, `out_valid` is 0 and all three outputs are zero.
- R10: `wr_en` with `wr_uniform` 0 writes `wr_data` to temporary `wr_addr`. With `wr_uniform` 1 it writes to uniform `wr_addr`. The written value is read by any strobe in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Array write strobe |
| wr_uniform | input | 1 | Write target: 0 temporary, 1 uniform |
| wr_addr | input | max(clog2(TEMP_DEPTH), clog2(UNIF_DEPTH)) | Write index |
| wr_data | input | 4*DATA_W | Vector to write, x lowest |
| front_facing | input | 1 | Front-facing flag for the internal group |
| addr_reg | input | 4*ADDR_W | Address register, four signed components, x lowest |
| in_valid | input | 1 | Instruction strobe |
| inst_w | input | 96 | Instruction words 1..3 |
| out_valid | output | 1 | Operands valid |
| src0_vec | output | 4*DATA_W | Operand 0 after modifiers |
| src1_vec | output | 4*DATA_W | Operand 1 after modifiers |
| src2_vec | output | 4*DATA_W | Operand 2 after modifiers |

## Verification
A wrong index sum or group decode shows up in the cycle after the strobe: the output vector names the wrong entry. Every stored entry encodes its own index and component, so the bench can tell which entry was read. A wrong uniform-selection choice shows up in the same cycle as unequal vectors among the uniform operands, or as a vector from a skipped operand. A stale or wrongly enabled pipeline register shows up in the next idle cycle as an output that changed while no strobe was present.

// File: rtl/ofu_pkg.sv
package ofu_pkg;
  localparam int IDX_W  = 9;
  localparam int SWZ_W  = 8;
  localparam int MODE_W = 3;
  localparam int GRP_W  = 3;

  typedef enum logic [1:0] {
    SRC_TEMP     = 2'd0,
    SRC_INTERNAL = 2'd1,
    SRC_UNIFORM  = 2'd2
  } src_kind_e;

  typedef struct packed {
    logic              use_f;
    logic [IDX_W-1:0]  idx;
    logic [SWZ_W-1:0]  swz;
    logic              neg;
    logic              absv;
    logic [MODE_W-1:0] amode;
    logic [GRP_W-1:0]  grp;
  } opnd_t;

  // w: word1 in [31:0], word2 in [63:32], word3 in [95:64]
  function automatic opnd_t pick_operand(input logic [95:0] w, input int k);
    opnd_t o;
    case (k)
      0: begin
        o.use_f = w[11];       o.idx  = w[20:12];    o.swz   = w[29:22];
        o.neg   = w[30];       o.absv = w[31];       o.amode = w[34:32];
        o.grp   = w[37:35];
      end
      1: begin
        o.use_f = w[38];       o.idx  = w[47:39];    o.swz   = w[56:49];
        o.neg   = w[57];       o.absv = w[58];       o.amode = w[61:59];
        o.grp   = w[66:64];
      end
      default: begin
        o.use_f = w[67];       o.idx  = w[76:68];    o.swz   = w[85:78];
        o.neg   = w[86];       o.absv = w[87];       o.amode = w[91:89];
        o.grp   = w[94:92];
      end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/ofu_ram.sv
module ofu_ram #(
  parameter int W     = 128,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ofu_index_calc.sv
module ofu_index_calc import ofu_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int TEMP_AW   = 6,
  parameter int UNIF_AW   = 8,
  parameter int UNIF_BANK = 128
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic [MODE_W-1:0]   amode,
  input  logic [1:0]          grp,
  input  logic [4*ADDR_W-1:0] addr_reg,
  output logic [TEMP_AW-1:0]  temp_idx,
  output logic [UNIF_AW-1:0]  uni_idx,
  output src_kind_e           kind
);
  localparam int SUM_W = 32;

  logic [SUM_W-1:0] off, tsum, usum;

  function automatic logic [SUM_W-1:0] sext(input logic [ADDR_W-1:0] v);
    return {{(SUM_W-ADDR_W){v[ADDR_W-1]}}, v};
  endfunction

  always_comb begin
    case (amode)
      3'd1:    off = sext(addr_reg[0*ADDR_W +: ADDR_W]);
      3'd2:    off = sext(addr_reg[1*ADDR_W +: ADDR_W]);
      3'd3:    off = sext(addr_reg[2*ADDR_W +: ADDR_W]);
      3'd4:    off = sext(addr_reg[3*ADDR_W +: ADDR_W]);
      default: off = '0;
    endcase
    tsum = SUM_W'(idx) + off;
    usum = tsum + (grp[0] ? SUM_W'(UNIF_BANK) : '0);
    temp_idx = tsum[TEMP_AW-1:0];
    uni_idx  = usum[UNIF_AW-1:0];
    case (grp)
      2'd0:    kind = SRC_TEMP;
      2'd1:    kind = SRC_INTERNAL;
      default: kind = SRC_UNIFORM;
    endcase
  end
endmodule

// File: rtl/ofu_modifier.sv
module ofu_modifier #(
  parameter int DATA_W = 32
) (
  input  logic [4*DATA_W-1:0] vin,
  input  logic [7:0]          swz,
  input  logic                absv,
  input  logic                neg,
  output logic [4*DATA_W-1:0] vout
);
  for (genvar c = 0; c < 4; c++) begin : g_comp
    logic [1:0]        sel;
    logic [DATA_W-1:0] picked;
    assign sel    = swz[2*c +: 2];
    assign picked = vin[sel*DATA_W +: DATA_W];
    assign vout[c*DATA_W +: DATA_W] =
      {(picked[DATA_W-1] & ~absv) ^ neg, picked[DATA_W-2:0]};
  end
endmodule

// File: rtl/shader_opfetch.sv
module shader_opfetch import ofu_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int TEMP_DEPTH = 64,
  parameter int UNIF_DEPTH = 256,
  parameter int UNIF_BANK  = 128,
  parameter int ADDR_W     = 16,
  parameter logic [DATA_W-1:0] FACING_VAL = 32'h3F800000,
  localparam int VEC_W   = 4*DATA_W,
  localparam int TEMP_AW = $clog2(TEMP_DEPTH),
  localparam int UNIF_AW = $clog2(UNIF_DEPTH),
  localparam int WADDR_W = (TEMP_AW > UNIF_AW) ? TEMP_AW : UNIF_AW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_uniform,
  input  logic [WADDR_W-1:0]  wr_addr,
  input  logic [VEC_W-1:0]    wr_data,
  input  logic                front_facing,
  input  logic [4*ADDR_W-1:0] addr_reg,
  input  logic                in_valid,
  input  logic [95:0]         inst_w,
  output logic                out_valid,
  output logic [VEC_W-1:0]    src0_vec,
  output logic [VEC_W-1:0]    src1_vec,
  output logic [VEC_W-1:0]    src2_vec
);
  localparam int NSRC = 3;

  opnd_t              op_d   [NSRC];
  src_kind_e          kind_d [NSRC];
  logic [TEMP_AW-1:0] tidx   [NSRC];
  logic [UNIF_AW-1:0] uidx   [NSRC];
  logic [VEC_W-1:0]   temp_rd[NSRC];
  logic [VEC_W-1:0]   res    [NSRC];
  logic [VEC_W-1:0]   uni_rd;
  logic [UNIF_AW-1:0] uni_sel;
  logic [VEC_W-1:0]   int_vec;

  opnd_t              op_q   [NSRC];
  src_kind_e          kind_q [NSRC];
  logic               ff_q;
  logic               vld_q;

  // Per-operand decode, index, private temp copy and modifier path
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [VEC_W-1:0] raw, modded;

    assign op_d[k] = pick_operand(inst_w, k);

    ofu_index_calc #(
      .ADDR_W(ADDR_W), .TEMP_AW(TEMP_AW), .UNIF_AW(UNIF_AW), .UNIF_BANK(UNIF_BANK)
    ) idx_i (
      .idx     (op_d[k].idx),
      .amode   (op_d[k].amode),
      .grp     (op_d[k].grp[1:0]),
      .addr_reg(addr_reg),
      .temp_idx(tidx[k]),
      .uni_idx (uidx[k]),
      .kind    (kind_d[k])
    );

    ofu_ram #(.W(VEC_W), .DEPTH(TEMP_DEPTH), .AW(TEMP_AW)) tram_i (
      .clk  (clk),
      .we   (wr_en & ~wr_uniform),
      .waddr(wr_addr[TEMP_AW-1:0]),
      .wdata(wr_data),
      .re   (in_valid),
      .raddr(tidx[k]),
      .rdata(temp_rd[k])
    );

    always_comb begin
      case (kind_q[k])
        SRC_TEMP:     raw = temp_rd[k];
        SRC_INTERNAL: raw = int_vec;
        default:      raw = uni_rd;
      endcase
    end

    ofu_modifier #(.DATA_W(DATA_W)) mod_i (
      .vin (raw),
      .swz (op_q[k].swz),
      .absv(op_q[k].absv),
      .neg (op_q[k].neg),
      .vout(modded)
    );

    assign res[k] = op_q[k].use_f ? modded : '0;
  end

  // Single uniform read port: last used uniform operand wins
  always_comb begin
    uni_sel = uidx[0];
    for (int k = 0; k < NSRC; k++) begin
      if (op_d[k].use_f && kind_d[k] == SRC_UNIFORM) uni_sel = uidx[k];
    end
  end

  ofu_ram #(.W(VEC_W), .DEPTH(UNIF_DEPTH), .AW(UNIF_AW)) uram_i (
    .clk  (clk),
    .we   (wr_en & wr_uniform),
    .waddr(wr_addr[UNIF_AW-1:0]),
    .wdata(wr_data),
    .re   (in_valid),
    .raddr(uni_sel),
    .rdata(uni_rd)
  );

  assign int_vec = {{(VEC_W-DATA_W){1'b0}}, ff_q ? FACING_VAL : {DATA_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      ff_q  <= 1'b0;
      for (int k = 0; k < NSRC; k++) begin
        op_q[k]   <= '0;
        kind_q[k] <= SRC_TEMP;
      end
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        ff_q <= front_facing;
        for (int k = 0; k < NSRC; k++) begin
          op_q[k]   <= op_d[k];
          kind_q[k] <= kind_d[k];
        end
      end
    end
  end

  assign out_valid = vld_q;
  assign src0_vec  = res[0];
  assign src1_vec  = res[1];
  assign src2_vec  = res[2];
endmodule

// File: rtl/ofu_checker.sv
module ofu_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [95:0]      inst_w,
  input logic             out_valid,
  input logic [VEC_W-1:0] src0_vec,
  input logic [VEC_W-1:0] src1_vec,
  input logic [VEC_W-1:0] src2_vec
);
  localparam int DW = VEC_W / 4;

  // R8: valid follows the strobe by one cycle
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8: outputs hold without a strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(src0_vec) && $stable(src1_vec) && $stable(src2_vec)));

  // R2: unused operands come out as zero
  p_unused0_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !inst_w[11]) |=> (src0_vec == '0));
  p_unused2_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !inst_w[67]) |=> (src2_vec == '0));

  // R6: absolute without negate leaves every sign clear
  p_abs_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inst_w[11] && inst_w[31] && !inst_w[30]) |=>
      (src0_vec[DW-1] | src0_vec[2*DW-1] | src0_vec[3*DW-1] | src0_vec[4*DW-1]) == 1'b0);

  // R7: two uniform operands with identical modifiers see the same vector
  p_uniform_bcast_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inst_w[11] && inst_w[67] && inst_w[36] && inst_w[93] &&
     inst_w[31:22] == inst_w[87:78]) |=> (src0_vec == src2_vec));
endmodule

bind shader_opfetch ofu_checker #(.VEC_W(VEC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .inst_w   (inst_w),
  .out_valid(out_valid),
  .src0_vec (src0_vec),
  .src1_vec (src1_vec),
  .src2_vec (src2_vec)
);

// File: tb/shader_opfetch_tb_top.sv
module shader_opfetch_tb_top;
  localparam int TD = 16;
  localparam int UD = 256;
  localparam int AW = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, wr_uniform = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [127:0] wr_data = '0;
  logic         front_facing = 1'b0;
  logic [31:0]  addr_reg = {8'hFF, 8'd100, 8'hFB, 8'd3}; // w=-1 z=100 y=-5 x=3
  logic         in_valid = 1'b0;
  logic [95:0]  inst_w = '0;
  logic         out_valid;
  logic [127:0] s0, s1, s2;

  int n_chk = 0, n_fail = 0;
  int f_use[3], f_idx[3], f_swz[3], f_neg[3], f_abs[3], f_am[3], f_grp[3];
  logic ff_m;

  shader_opfetch #(.TEMP_DEPTH(TD), .UNIF_DEPTH(UD), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_uniform(wr_uniform), .wr_addr(wr_addr),
    .wr_data(wr_data), .front_facing(front_facing), .addr_reg(addr_reg),
    .in_valid(in_valid), .inst_w(inst_w), .out_valid(out_valid),
    .src0_vec(s0), .src1_vec(s1), .src2_vec(s2));

  always #5 clk = ~clk;

  function automatic logic [31:0] tval(int i, int c);
    return {1'((i + c) % 2), 7'h10, 8'(i), 14'h0, 2'(c)};
  endfunction
  function automatic logic [31:0] uval(int i, int c);
    return {1'((i ^ c) & 1), 7'h20, 8'(i), 14'h0, 2'(c)};
  endfunction
  function automatic logic [127:0] tvec(int i);
    logic [127:0] v;
    for (int c = 0; c < 4; c++) v[c*32 +: 32] = tval(i, c);
    return v;
  endfunction
  function automatic logic [127:0] uvec(int i);
    logic [127:0] v;
    for (int c = 0; c < 4; c++) v[c*32 +: 32] = uval(i, c);
    return v;
  endfunction
  function automatic int aoff(int am); // R4
    case (am)
      1: return 3;
      2: return -5;
      3: return 100;
      4: return -1;
      default: return 0;
    endcase
  endfunction
  function automatic int wrapm(int x, int m);
    return ((x % m) + m) % m;
  endfunction

  function automatic logic [127:0] get_out(int k);
    return (k == 0) ? s0 : (k == 1) ? s1 : s2;
  endfunction

  // Reference model built from the requirements
  function automatic logic [127:0] exp_op(int k);
    logic [127:0] raw, r;
    int g, u;
    if (f_use[k] == 0) return '0;                            // R2
    g = f_grp[k] % 4;                                        // R3
    if (g == 0) raw = tvec(wrapm(f_idx[k] + aoff(f_am[k]), TD));
    else if (g == 1) raw = {96'b0, ff_m ? 32'h3F800000 : 32'h0};
    else begin
      u = k;                                                 // R7
      for (int j = 0; j < 3; j++)
        if (f_use[j] != 0 && (f_grp[j] % 4) >= 2) u = j;
      raw = uvec(wrapm(128*(f_grp[u] % 2) + f_idx[u] + aoff(f_am[u]), UD));
    end
    for (int c = 0; c < 4; c++) begin                        // R5, R6
      logic [31:0] v;
      v = raw[((f_swz[k] >> (2*c)) & 3)*32 +: 32];
      if (f_abs[k] != 0) v[31] = 1'b0;
      if (f_neg[k] != 0) v[31] = ~v[31];
      r[c*32 +: 32] = v;
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1: field placement
  task automatic encode();
    inst_w = '0;
    for (int k = 0; k < 3; k++) begin
      case (k)
        0: begin
          inst_w[11] = f_use[0][0]; inst_w[20:12] = 9'(f_idx[0]); inst_w[29:22] = 8'(f_swz[0]);
          inst_w[30] = f_neg[0][0]; inst_w[31] = f_abs[0][0];
          inst_w[34:32] = 3'(f_am[0]); inst_w[37:35] = 3'(f_grp[0]);
        end
        1: begin
          inst_w[38] = f_use[1][0]; inst_w[47:39] = 9'(f_idx[1]); inst_w[56:49] = 8'(f_swz[1]);
          inst_w[57] = f_neg[1][0]; inst_w[58] = f_abs[1][0];
          inst_w[61:59] = 3'(f_am[1]); inst_w[66:64] = 3'(f_grp[1]);
        end
        default: begin
          inst_w[67] = f_use[2][0]; inst_w[76:68] = 9'(f_idx[2]); inst_w[85:78] = 8'(f_swz[2]);
          inst_w[86] = f_neg[2][0]; inst_w[87] = f_abs[2][0];
          inst_w[91:89] = 3'(f_am[2]); inst_w[94:92] = 3'(f_grp[2]);
        end
      endcase
    end
  endtask

  task automatic run_instr(string tag);
    logic [127:0] held[3];
    encode();
    front_facing = ff_m;
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check(out_valid === 1'b1, "R8 valid", {127'b0, out_valid}, 128'd1);
    for (int k = 0; k < 3; k++) begin
      held[k] = get_out(k);
      check(get_out(k) === exp_op(k), (f_use[k] == 0) ? "R2" : tag, get_out(k), exp_op(k));
    end
    inst_w = ~inst_w; front_facing = ~front_facing;           // R8: no strobe, no change
    @(negedge clk);
    check(out_valid === 1'b0, "R8 idle", {127'b0, out_valid}, 128'd0);
    for (int k = 0; k < 3; k++)
      check(get_out(k) === held[k], "R8 hold", get_out(k), held[k]);
  endtask

  task automatic wr(bit uni, int a, logic [127:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_uniform = uni; wr_addr = 8'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int swz_set[4];
    swz_set = '{8'hE4, 8'h1B, 8'h00, 8'hB1};
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid === 1'b0, "R9 valid", {127'b0, out_valid}, 128'd0);
    check(s0 === '0 && s1 === '0 && s2 === '0, "R9 data", s0 | s1 | s2, '0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && s1 === '0, "R9 after", s1, '0);

    // R10: load arrays through the write port
    for (int i = 0; i < TD; i++) wr(1'b0, i, tvec(i));
    for (int i = 0; i < UD; i++) wr(1'b1, i, uvec(i));

    // Sweep single operands over groups R3, modes R4, swizzles R5, modifiers R6
    for (int k = 0; k < 3; k++)
      for (int g = 0; g < 8; g++)
        for (int am = 0; am < 6; am++)
          for (int s = 0; s < 4; s++)
            for (int m = 0; m < 4; m++) begin
              for (int j = 0; j < 3; j++) begin
                f_use[j] = 0; f_idx[j] = 0; f_swz[j] = 0; f_neg[j] = 0;
                f_abs[j] = 0; f_am[j] = 0; f_grp[j] = 0;
              end
              f_use[k] = 1; f_idx[k] = (g*37 + am*11 + k*5 + s*101) % 512;
              f_swz[k] = swz_set[s]; f_neg[k] = m & 1; f_abs[k] = m >> 1;
              f_am[k] = am; f_grp[k] = g;
              ff_m = 1'((am + s) % 2);
              run_instr("R1 R3 R4 R5 R6");
            end

    // Uniform sharing across all use masks and group mixes R7, R2
    for (int mask = 0; mask < 8; mask++)
      for (int gc = 0; gc < 512; gc++) begin
        for (int j = 0; j < 3; j++) begin
          f_use[j] = (mask >> j) & 1;
          f_grp[j] = (gc >> (3*j)) & 7;
          f_idx[j] = (13 + j*60 + f_grp[j]*7 + mask) % 512;
          f_am[j]  = (j + f_grp[j]) % 6;
          f_swz[j] = swz_set[(j + gc) % 4];
          f_neg[j] = (j + gc) & 1;
          f_abs[j] = (gc >> 2) & 1;
        end
        ff_m = 1'(gc % 2);
        run_instr("R7");
      end

    // R10: overwrite one temp and one uniform, read back
    wr(1'b0, 5, 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978);
    wr(1'b1, 200, 128'hFEDC_BA98_7654_3210_1111_2222_3333_4444);
    for (int j = 0; j < 3; j++) begin
      f_use[j] = 0; f_swz[j] = 8'hE4; f_neg[j] = 0; f_abs[j] = 0; f_am[j] = 0;
    end
    f_use[0] = 1; f_grp[0] = 0; f_idx[0] = 5;
    f_use[1] = 1; f_grp[1] = 2; f_idx[1] = 200; f_grp[2] = 0; f_idx[2] = 0;
    encode();
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check(s0 === 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978, "R10 temp", s0,
          128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978);
    check(s1 === 128'hFEDC_BA98_7654_3210_1111_2222_3333_4444, "R10 uniform", s1,
          128'hFEDC_BA98_7654_3210_1111_2222_3333_4444);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule